// File: doc/BRIEF.md
# Configurable Tile Register File

The block holds eight two-dimensional matrix tiles. Each tile is a stack of up to sixteen rows, and each row is up to 64 bytes wide. Software sets the block up by loading a 64-byte configuration image. The image selects a palette and gives every tile its own row count and row width in bytes. The accepted image can be read back unchanged at any time.

Once a shape-defining palette is active, tile data moves one whole row at a time. A write port fills a row and a read port fetches a row. The block also has two clearing commands: a zero command that empties a single tile, and a release command that returns the configuration and every tile to the power-up state.

The block checks every image and every row access against the stored shapes. An image that breaks the rules is refused and raises an error pulse. A row access that falls outside a tile's configured shape, or that arrives while the block is unconfigured, also raises an error pulse and never touches storage.

Top module: `tilerf_top`

## Requirements
- R1: After reset, `cfg_out` is all zero (palette 0), and `cfg_err`, `wr_err`, `rd_err` and `rd_data` are zero.
- R2: The image layout is as follows. Byte 0 is the palette id. Bytes 16+2t (low byte) and 17+2t (high byte) hold the row width in bytes of tile t. Byte 48+t holds the row count of tile t. Every other byte must be zero. An image with palette 1, every row count at most 16 and every row width at most 64 is accepted: from the next cycle `cfg_out` equals that image and `cfg_err` stays low.
- R3: An image is refused in any of these cases: the palette id is above 1, a row count is above 16, a row width is above 64, a reserved byte is nonzero, or the palette id is 0 while some other byte is nonzero. On a refused image, `cfg_err` is high for exactly the next cycle, and both `cfg_out` and the tile contents stay as they were.
- R4: While the palette is 0, every row write and row read raises its error flag in the next cycle. A read in this state returns zero, and a write in this state stores nothing.
- R5: A row write in range stores the row. A read of that row returns the data one cycle after `rd_en`. Bytes at positions at or beyond the tile's row width read back as zero.
- R6: A row write or read whose row index is at or beyond the tile's row count raises the matching error flag in the next cycle. Such a write is discarded, and such a read returns zero.
- R7: `zero_en` with palette 1 makes every row of tile `zero_tile` read as zero. Other tiles are unaffected.
- R8: `rel` clears the configuration to all zero and empties every tile. Rows read after a later reconfiguration return zero.
- R9: Loading an all-zero image is accepted without an error and acts exactly like `rel`.
- R10: Simultaneous commands resolve as follows. `rel` wins over `cfg_load` in the same cycle. A zero command wins over a write to the same tile in the same cycle. A read sees the row contents from before a write issued in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_load | input | 1 | Load `cfg_in` as the new configuration image |
| cfg_in | input | 512 | Configuration image, byte i at bits 8i+7:8i |
| cfg_out | output | 512 | Currently accepted configuration image |
| cfg_err | output | 1 | Image refused (one-cycle pulse) |
| rel | input | 1 | Release: back to the initial state |
| zero_en | input | 1 | Clear one tile |
| zero_tile | input | 3 | Tile to clear |
| wr_en | input | 1 | Row write strobe |
| wr_tile | input | 3 | Tile written |
| wr_row | input | 4 | Row written |
| wr_data | input | 512 | Row write data, byte b at bits 8b+7:8b |
| wr_err | output | 1 | Write refused (one-cycle pulse) |
| rd_en | input | 1 | Row read strobe |
| rd_tile | input | 3 | Tile read |
| rd_row | input | 4 | Row read |
| rd_data | output | 512 | Row read data, valid the cycle after `rd_en` |
| rd_err | output | 1 | Read refused (one-cycle pulse) |

## Verification
A corrupted stored image shows up on `cfg_out` in the cycle after the load. It also shifts the error boundaries of the next row access, so one read per tile near the edge of its shape exposes it. A lost or stale row-valid bit, or a mis-indexed storage row, appears at the very next read of that row as wrong or non-zero data. The sweeps therefore write every row of every tile and read every row back, each one a single cycle after its strobe. A clearing command that misses a tile, or one that reaches too far, is caught by the full read-back that follows each zero, release and all-zero load.

// File: rtl/tilerf_pkg.sv
package tilerf_pkg;
  localparam int NTILE     = 8;
  localparam int MAXR      = 16;
  localparam int RBYTES    = 64;
  localparam int CFGB      = 64;
  localparam int TW        = $clog2(NTILE);
  localparam int RW        = $clog2(MAXR);
  localparam int RBITS     = RBYTES * 8;
  localparam int CBITS     = CFGB * 8;
  localparam int BPR_BASE  = 16;
  localparam int ROWS_BASE = 48;

  function automatic logic [7:0] img_byte(input logic [CBITS-1:0] img, input int i);
    return img[i*8 +: 8];
  endfunction

  function automatic logic [7:0] img_palette(input logic [CBITS-1:0] img);
    return img_byte(img, 0);
  endfunction

  function automatic logic [15:0] img_bpr(input logic [CBITS-1:0] img, input int t);
    return {img_byte(img, BPR_BASE + 2*t + 1), img_byte(img, BPR_BASE + 2*t)};
  endfunction

  function automatic logic [7:0] img_rows(input logic [CBITS-1:0] img, input int t);
    return img_byte(img, ROWS_BASE + t);
  endfunction

  // Legality of an image: palette, shape limits and reserved bytes.
  function automatic logic img_valid(input logic [CBITS-1:0] img);
    logic ok;
    ok = 1'b1;
    for (int i = 0; i < CFGB; i++) begin
      if (!((i == 0) || (i >= BPR_BASE && i < BPR_BASE + 2*NTILE) ||
            (i >= ROWS_BASE && i < ROWS_BASE + NTILE)) && img_byte(img, i) != 8'd0)
        ok = 1'b0;
    end
    if (img_palette(img) > 8'd1) ok = 1'b0;
    if (img_palette(img) == 8'd0 && img != '0) ok = 1'b0;
    for (int t = 0; t < NTILE; t++) begin
      if (img_rows(img, t) > 8'(MAXR)) ok = 1'b0;
      if (img_bpr(img, t) > 16'(RBYTES)) ok = 1'b0;
    end
    return ok;
  endfunction

  function automatic logic [RBITS-1:0] byte_mask(input logic [15:0] bpr);
    logic [RBITS-1:0] m;
    for (int b = 0; b < RBYTES; b++) m[b*8 +: 8] = (16'(b) < bpr) ? 8'hFF : 8'h00;
    return m;
  endfunction
endpackage

// File: rtl/tilerf_cfg.sv
module tilerf_cfg
  import tilerf_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             rel,
  input  logic             load,
  input  logic [CBITS-1:0] img_in,
  output logic [CBITS-1:0] img_q,
  output logic             err,
  output logic             clr_all
);
  logic in_ok;
  assign in_ok   = img_valid(img_in);
  assign clr_all = rel | (load & in_ok & (img_palette(img_in) == 8'd0));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      img_q <= '0;
      err   <= 1'b0;
    end else begin
      err <= 1'b0;
      if (rel) img_q <= '0;
      else if (load) begin
        if (in_ok) img_q <= img_in;
        else       err   <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/tilerf_store.sv
module tilerf_store
  import tilerf_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr_all,
  input  logic             zero_go,
  input  logic [TW-1:0]    zero_tile,
  input  logic             wr_go,
  input  logic [TW-1:0]    wr_tile,
  input  logic [RW-1:0]    wr_row,
  input  logic [RBITS-1:0] wr_row_data,
  input  logic             rd_go,
  input  logic [TW-1:0]    rd_tile,
  input  logic [RW-1:0]    rd_row,
  input  logic [RBITS-1:0] rd_mask,
  output logic [RBITS-1:0] rd_data
);
  logic [RBITS-1:0] mem [NTILE*MAXR];
  logic [NTILE-1:0][MAXR-1:0] vld;

  for (genvar t = 0; t < NTILE; t++) begin : g_tile
    logic [MAXR-1:0] v;
    always_ff @(posedge clk) begin
      if (!rst_n)                                   v <= '0;
      else if (clr_all)                             v <= '0;
      else if (zero_go && zero_tile == TW'(t))      v <= '0;
      else if (wr_go && wr_tile == TW'(t))          v[wr_row] <= 1'b1;
    end
    assign vld[t] = v;
  end

  always_ff @(posedge clk) begin
    if (wr_go) mem[{wr_tile, wr_row}] <= wr_row_data;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) rd_data <= '0;
    else if (rd_go && vld[rd_tile][rd_row]) rd_data <= mem[{rd_tile, rd_row}] & rd_mask;
    else rd_data <= '0;
  end
endmodule

// File: rtl/tilerf_top.sv
module tilerf_top
  import tilerf_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfg_load,
  input  logic [CBITS-1:0] cfg_in,
  output logic [CBITS-1:0] cfg_out,
  output logic             cfg_err,
  input  logic             rel,
  input  logic             zero_en,
  input  logic [TW-1:0]    zero_tile,
  input  logic             wr_en,
  input  logic [TW-1:0]    wr_tile,
  input  logic [RW-1:0]    wr_row,
  input  logic [RBITS-1:0] wr_data,
  output logic             wr_err,
  input  logic             rd_en,
  input  logic [TW-1:0]    rd_tile,
  input  logic [RW-1:0]    rd_row,
  output logic [RBITS-1:0] rd_data,
  output logic             rd_err
);
  logic clr_all, pal_on, wr_ok, rd_ok, wr_go, rd_go, zero_go;
  logic [RBITS-1:0] wr_masked, rd_mask;

  tilerf_cfg u_cfg (
    .clk(clk), .rst_n(rst_n), .rel(rel), .load(cfg_load), .img_in(cfg_in),
    .img_q(cfg_out), .err(cfg_err), .clr_all(clr_all)
  );

  assign pal_on    = (img_palette(cfg_out) == 8'd1);
  assign wr_ok     = pal_on && (8'(wr_row) < img_rows(cfg_out, int'(wr_tile)));
  assign rd_ok     = pal_on && (8'(rd_row) < img_rows(cfg_out, int'(rd_tile)));
  assign wr_go     = wr_en && wr_ok;
  assign rd_go     = rd_en && rd_ok;
  assign zero_go   = zero_en && pal_on;
  assign wr_masked = wr_data & byte_mask(img_bpr(cfg_out, int'(wr_tile)));
  assign rd_mask   = byte_mask(img_bpr(cfg_out, int'(rd_tile)));

  tilerf_store u_store (
    .clk(clk), .rst_n(rst_n), .clr_all(clr_all),
    .zero_go(zero_go), .zero_tile(zero_tile),
    .wr_go(wr_go), .wr_tile(wr_tile), .wr_row(wr_row), .wr_row_data(wr_masked),
    .rd_go(rd_go), .rd_tile(rd_tile), .rd_row(rd_row), .rd_mask(rd_mask),
    .rd_data(rd_data)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wr_err <= 1'b0;
      rd_err <= 1'b0;
    end else begin
      wr_err <= wr_en && !wr_ok;
      rd_err <= rd_en && !rd_ok;
    end
  end
endmodule

// File: rtl/tilerf_chk.sv
module tilerf_chk
  import tilerf_pkg::*;
(
  input logic             clk,
  input logic             rst_n,
  input logic             cfg_load,
  input logic [CBITS-1:0] cfg_in,
  input logic             rel,
  input logic [CBITS-1:0] cfg_out,
  input logic             cfg_err,
  input logic             wr_en,
  input logic [TW-1:0]    wr_tile,
  input logic [RW-1:0]    wr_row,
  input logic             wr_err,
  input logic             rd_en,
  input logic [RBITS-1:0] rd_data,
  input logic             rd_err
);
  p_pal_legal_r2: assert property (@(posedge clk) disable iff (!rst_n)
    img_palette(cfg_out) <= 8'd1);

  p_reject_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_load && !rel && !img_valid(cfg_in) |=> cfg_err && $stable(cfg_out));

  p_pal0_read_r4: assert property (@(posedge clk) disable iff (!rst_n)
    rd_en && img_palette(cfg_out) == 8'd0 |=> rd_err && rd_data == '0);

  p_err_zero_r6: assert property (@(posedge clk) disable iff (!rst_n)
    rd_err |-> rd_data == '0);

  p_wr_range_r6: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en && img_palette(cfg_out) == 8'd1 && 8'(wr_row) >= img_rows(cfg_out, int'(wr_tile))
    |=> wr_err);

  p_release_r8: assert property (@(posedge clk) disable iff (!rst_n)
    rel |=> cfg_out == '0 && !cfg_err);
endmodule

bind tilerf_top tilerf_chk u_chk (
  .clk(clk), .rst_n(rst_n), .cfg_load(cfg_load), .cfg_in(cfg_in), .rel(rel),
  .cfg_out(cfg_out), .cfg_err(cfg_err), .wr_en(wr_en), .wr_tile(wr_tile),
  .wr_row(wr_row), .wr_err(wr_err), .rd_en(rd_en), .rd_data(rd_data), .rd_err(rd_err)
);

// File: tb/tb_tilerf_top.sv
module tb_tilerf_top;
  localparam int CLK_PERIOD = 10;
  localparam int NT = 8, NR = 16, NB = 64;

  logic clk = 1'b0, rst_n = 1'b0;
  logic cfg_load = 0, rel = 0, zero_en = 0, wr_en = 0, rd_en = 0;
  logic [511:0] cfg_in = '0, wr_data = '0;
  logic [2:0] zero_tile = '0, wr_tile = '0, rd_tile = '0;
  logic [3:0] wr_row = '0, rd_row = '0;
  logic [511:0] cfg_out, rd_data;
  logic cfg_err, wr_err, rd_err;

  int checks = 0, fails = 0;
  bit finished = 0;
  int t_rows [NT];
  int t_bpr  [NT];
  int cur_pal = 0;
  logic [511:0] model [NT][NR];

  always #(CLK_PERIOD/2) clk = ~clk;

  tilerf_top dut (
    .clk(clk), .rst_n(rst_n), .cfg_load(cfg_load), .cfg_in(cfg_in), .cfg_out(cfg_out),
    .cfg_err(cfg_err), .rel(rel), .zero_en(zero_en), .zero_tile(zero_tile),
    .wr_en(wr_en), .wr_tile(wr_tile), .wr_row(wr_row), .wr_data(wr_data), .wr_err(wr_err),
    .rd_en(rd_en), .rd_tile(rd_tile), .rd_row(rd_row), .rd_data(rd_data), .rd_err(rd_err)
  );

  task automatic chk(input string req, input logic [511:0] act, input logic [511:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [511:0] pat(input int t, input int r, input int seed);
    logic [511:0] d;
    for (int b = 0; b < NB; b++) d[b*8 +: 8] = 8'(t*29 + r*7 + b*3 + seed*13 + 1);
    return d;
  endfunction

  function automatic logic [511:0] keep(input logic [511:0] d, input int n);
    logic [511:0] o;
    for (int b = 0; b < NB; b++) o[b*8 +: 8] = (b < n) ? d[b*8 +: 8] : 8'h00;
    return o;
  endfunction

  function automatic logic [511:0] mk_img(input int pal);
    logic [511:0] img = '0;
    img[7:0] = 8'(pal);
    for (int t = 0; t < NT; t++) begin
      img[(16 + 2*t)*8 +: 16] = 16'(t_bpr[t]);
      img[(48 + t)*8 +: 8]    = 8'(t_rows[t]);
    end
    return img;
  endfunction

  task automatic step;
    @(negedge clk);
  endtask

  task automatic load(input logic [511:0] img);
    cfg_in = img; cfg_load = 1; step; cfg_load = 0;
  endtask

  task automatic clear_model;
    for (int t = 0; t < NT; t++) for (int r = 0; r < NR; r++) model[t][r] = '0;
  endtask

  task automatic write_all(input int seed, input string req);
    for (int t = 0; t < NT; t++) for (int r = 0; r < NR; r++) begin
      bit bad;
      bad = (cur_pal != 1) || (r >= t_rows[t]);
      wr_en = 1; wr_tile = 3'(t); wr_row = 4'(r); wr_data = pat(t, r, seed);
      step; wr_en = 0;
      chk({req, " wr_err"}, 512'(wr_err), 512'(bad));
      if (!bad) model[t][r] = keep(pat(t, r, seed), t_bpr[t]);
    end
  endtask

  task automatic read_one(input int t, input int r, input string req);
    bit bad;
    bad = (cur_pal != 1) || (r >= t_rows[t]);
    rd_en = 1; rd_tile = 3'(t); rd_row = 4'(r);
    step; rd_en = 0;
    chk({req, " rd_err"}, 512'(rd_err), 512'(bad));
    chk({req, " rd_data"}, rd_data, bad ? '0 : keep(model[t][r], t_bpr[t]));
  endtask

  task automatic read_all(input string req);
    for (int t = 0; t < NT; t++) for (int r = 0; r < NR; r++) read_one(t, r, req);
  endtask

  initial begin
    #(CLK_PERIOD*150000);
    if (!finished) begin
      fails++;
      $display("FAIL watchdog actual=timeout expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [511:0] img_a, img_b, bad;
    clear_model();
    for (int t = 0; t < NT; t++) begin t_rows[t] = 0; t_bpr[t] = 0; end
    step; step; rst_n = 1; step;
    // R1 reset state
    chk("R1 cfg_out", cfg_out, '0);
    chk("R1 errs", 512'({cfg_err, wr_err, rd_err}), '0);
    chk("R1 rd_data", rd_data, '0);

    // R4 palette 0 accesses
    write_all(7, "R4");
    read_all("R4");

    // R2 valid image, R5/R6 sweep
    t_rows = '{16, 1, 5, 0, 16, 8, 3, 12};
    t_bpr  = '{64, 1, 17, 64, 0, 33, 64, 8};
    img_a = mk_img(1);
    load(img_a); cur_pal = 1;
    chk("R2 cfg_out", cfg_out, img_a);
    chk("R2 cfg_err", 512'(cfg_err), '0);
    write_all(1, "R5 R6");
    read_all("R5 R6");

    // R3 refused images
    for (int k = 0; k < 6; k++) begin
      bad = img_a;
      case (k)
        0: bad[7:0] = 8'd2;
        1: bad[(48+3)*8 +: 8] = 8'd17;
        2: bad[(16+12)*8 +: 16] = 16'd65;
        3: bad[5*8 +: 8] = 8'h40;
        4: bad[63*8 +: 8] = 8'h01;
        default: begin bad = '0; bad[(48+1)*8 +: 8] = 8'd4; end
      endcase
      load(bad);
      chk("R3 cfg_err", 512'(cfg_err), 512'(1));
      chk("R3 cfg_out kept", cfg_out, img_a);
      step;
      chk("R3 cfg_err pulse", 512'(cfg_err), '0);
    end
    read_all("R3 data kept");

    // R7 zero one tile
    zero_en = 1; zero_tile = 3'd2; step; zero_en = 0;
    for (int r = 0; r < NR; r++) model[2][r] = '0;
    read_all("R7");

    // R10 zero beats write, same tile
    zero_en = 1; zero_tile = 3'd0; wr_en = 1; wr_tile = 3'd0; wr_row = 4'd3; wr_data = pat(9, 9, 9);
    step; zero_en = 0; wr_en = 0;
    for (int r = 0; r < NR; r++) model[0][r] = '0;
    read_one(0, 3, "R10 zero over write");
    read_one(0, 0, "R10 zero over write");

    // R10 read sees pre-write contents
    wr_en = 1; wr_tile = 3'd5; wr_row = 4'd1; wr_data = pat(5, 1, 3);
    rd_en = 1; rd_tile = 3'd5; rd_row = 4'd1;
    step; wr_en = 0; rd_en = 0;
    chk("R10 read before write", rd_data, keep(model[5][1], t_bpr[5]));
    model[5][1] = keep(pat(5, 1, 3), t_bpr[5]);
    read_one(5, 1, "R10 write landed");

    // R10 release beats load; R8 release clears
    t_rows = '{16, 16, 16, 16, 16, 16, 16, 16};
    t_bpr  = '{64, 64, 64, 64, 64, 64, 64, 64};
    img_b = mk_img(1);
    rel = 1; cfg_load = 1; cfg_in = img_b; step; rel = 0; cfg_load = 0;
    chk("R10 release over load", cfg_out, '0);
    chk("R8 no cfg_err", 512'(cfg_err), '0);
    cur_pal = 0;
    read_one(1, 0, "R8 palette 0");
    load(img_b); cur_pal = 1;
    clear_model();
    read_all("R8 cleared");

    // R9 all-zero image acts as release
    write_all(2, "R5 full");
    read_all("R5 full");
    load('0); cur_pal = 0;
    chk("R9 cfg_out", cfg_out, '0);
    chk("R9 cfg_err", 512'(cfg_err), '0);
    read_one(4, 4, "R9 palette 0");
    load(img_b); cur_pal = 1;
    clear_model();
    read_all("R9 cleared");

    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule